// File: doc/BRIEF.md
# Serial Flash Command Protection Gate

This block sits between the command decoder of a serial NOR flash and the engine that drives the memory array. It sees each command once chip select has risen. That view is the opcode, the number of bits clocked in, the address and the first data byte. It then decides whether the command is carried out or silently dropped. The block keeps all the state that protection depends on: the write-enable latch, the four block-protect bits, the status lock bit, the deep power-down flag, the secured one-time-programmable (OTP) window flag and the customer OTP lock. It also runs the power-up write-inhibit timer.

When a program or erase command is accepted, the block raises a one-cycle launch with the operation kind, the address and whether the OTP window is the target. It then stays busy until the array engine reports completion. The region that the block-protect bits guard is taken from a 16-entry parameter table. Each entry gives how many blocks, counted down from the top of the array, are read-only. The sequence is power-on reset, wait for the inhibit timer, a write-enable command, then the modifying command.

Top module: `flash_wp_gate`

## Requirements
- R1: After synchronous reset, the status byte is 00h, the deep power-down and OTP window flags are 0, the customer lock is 0, `accept` is 0 and `wr_ready` is 0.
- R2: `wr_ready` rises once PUW_CYCLES clock cycles have passed since reset was released. Before then, the write-class commands are dropped and other commands are accepted. The write-class commands are 06h, 01h, 02h, 20h, D8h, C7h and 2Fh.
- R3: Write-enable (06h) sets the latch, which is status bit 1. Status write (01h), page program (02h), sector erase (20h), block erase (D8h), chip erase (C7h) and security write (2Fh) are dropped while the latch is clear.
- R4: The latch is cleared by write-disable (04h), by an accepted status write, and when `op_done` ends a program or erase. It is not cleared when that program or erase is launched.
- R5: A command is dropped unless `cmd_bits` is a multiple of 8 and covers a minimum byte count. The minimum is 2 bytes for 01h, 1 plus the address bytes for 03h, 20h and D8h, 2 plus the address bytes for 02h, and 1 byte for all other commands.
- R6: Status bits 5..2 index the table. Program and erase commands whose block index (address >> BLK_SHIFT) falls within the top PROT_BLKS[index] blocks are dropped. Chip erase is dropped whenever that count is non-zero.
- R7: An accepted status write loads bits 5..2 and bit 7 from `cmd_wdata[5:2]` and `cmd_wdata[7]`. With status bit 7 = 1 and `wprot_n` = 0, status writes are dropped. With status bit 7 = 0, `wprot_n` has no effect.
- R8: Power-down (B9h) sets `deep_pd`. While it is set, every command except ABh is dropped, and ABh clears the flag.
- R9: OTP enter (B1h) sets `otp_mode` and OTP exit (C1h) clears it. In the window, page program targets OTP bytes 0..OTP_BYTES-1 (`launch_otp` = 1), addresses past that range are dropped, and sector, block and chip erase are dropped.
- R10: `sec_reg[0]` mirrors `otp_factory_lock`. An accepted 2Fh sets `sec_reg[1]` and leaves the latch unchanged. While either bit is 1, page program in the OTP window is dropped.
- R11: A launch sets status bit 0 (busy). While busy, every command except status read (05h) is dropped, and `op_done` clears busy.
- R12: `accept` and `launch_kind` are valid for one cycle, on the clock edge after the one that samples `cmd_valid`. The `launch_kind` encoding is 0 none, 1 program, 2 sector erase, 3 block erase and 4 chip erase. `launch_addr` and `launch_otp` are captured at each launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | One-cycle strobe: a command has ended |
| cmd_op | input | 8 | Opcode |
| cmd_bits | input | LEN_W | Bits clocked in, opcode included |
| cmd_addr | input | ADDR_W | Address field |
| cmd_wdata | input | 8 | First data byte |
| wprot_n | input | 1 | Write-protect pin, active low |
| otp_factory_lock | input | 1 | Factory OTP lock fuse |
| op_done | input | 1 | Array engine finished the launched operation |
| accept | output | 1 | Command accepted (pulse) |
| launch_kind | output | 3 | Array operation launched (pulse) |
| launch_addr | output | ADDR_W | Address of last launch |
| launch_otp | output | 1 | Last launch targets the OTP window |
| stat_reg | output | 8 | Status byte {lock,0,protect[3:0],latch,busy} |
| sec_reg | output | 2 | {customer lock, factory lock} |
| deep_pd | output | 1 | Deep power-down active |
| otp_mode | output | 1 | OTP window selected |
| wr_ready | output | 1 | Power-up write inhibit expired |

## Verification
The bench builds the block with ADDR_W=12, BLK_SHIFT=8 and PUW_CYCLES=20. That gives sixteen 256-byte blocks and keeps the default table. With 16 blocks, protect index 3 guards addresses from C00h upward and index 4 guards from 800h upward, so both edges of a protected region can be reached with short addresses. The 20-cycle inhibit lets the bench measure the exact cycle at which `wr_ready` rises.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam logic [7:0] OP_STAT_WRITE = 8'h01;
    localparam logic [7:0] OP_PAGE_PROG  = 8'h02;
    localparam logic [7:0] OP_READ       = 8'h03;
    localparam logic [7:0] OP_WR_DISABLE = 8'h04;
    localparam logic [7:0] OP_STAT_READ  = 8'h05;
    localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
    localparam logic [7:0] OP_SECT_ERASE = 8'h20;
    localparam logic [7:0] OP_SEC_WRITE  = 8'h2F;
    localparam logic [7:0] OP_WAKE       = 8'hAB;
    localparam logic [7:0] OP_OTP_ENTER  = 8'hB1;
    localparam logic [7:0] OP_PWR_DOWN   = 8'hB9;
    localparam logic [7:0] OP_OTP_EXIT   = 8'hC1;
    localparam logic [7:0] OP_CHIP_ERASE = 8'hC7;
    localparam logic [7:0] OP_BLK_ERASE  = 8'hD8;

    typedef enum logic [2:0] {
        LK_NONE  = 3'd0,
        LK_PROG  = 3'd1,
        LK_SECT  = 3'd2,
        LK_BLOCK = 3'd3,
        LK_CHIP  = 3'd4
    } launch_kind_e;

    // protection-relevant state seen by the decision logic
    typedef struct packed {
        logic wel;
        logic srwd;
        logic dpd;
        logic otp;
        logic cust;
        logic busy;
    } gate_state_t;

    // outcome of one command
    typedef struct packed {
        logic         accept;
        logic         set_wel;
        logic         clr_wel;
        logic         wr_stat;
        logic         set_dpd;
        logic         clr_dpd;
        logic         set_otp;
        logic         clr_otp;
        logic         set_cust;
        launch_kind_e kind;
    } verdict_t;

    function automatic logic is_known(input logic [7:0] op);
        case (op)
            OP_STAT_WRITE, OP_PAGE_PROG, OP_READ, OP_WR_DISABLE, OP_STAT_READ,
            OP_WR_ENABLE, OP_SECT_ERASE, OP_SEC_WRITE, OP_WAKE, OP_OTP_ENTER,
            OP_PWR_DOWN, OP_OTP_EXIT, OP_CHIP_ERASE, OP_BLK_ERASE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_write_cls(input logic [7:0] op);
        case (op)
            OP_WR_ENABLE, OP_STAT_WRITE, OP_PAGE_PROG, OP_SECT_ERASE,
            OP_BLK_ERASE, OP_CHIP_ERASE, OP_SEC_WRITE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int unsigned min_bytes(input logic [7:0] op, input int unsigned abytes);
        case (op)
            OP_STAT_WRITE:                         return 2;
            OP_READ, OP_SECT_ERASE, OP_BLK_ERASE:  return 1 + abytes;
            OP_PAGE_PROG:                          return 2 + abytes;
            default:                               return 1;
        endcase
    endfunction

endpackage

// File: rtl/fwp_puw_timer.sv
module fwp_puw_timer #(
    parameter int unsigned CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    output logic expired
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q != CW'(CYCLES))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CW'(CYCLES));
endmodule

// File: rtl/fwp_prot_lookup.sv
module fwp_prot_lookup #(
    parameter int unsigned ADDR_W        = 24,
    parameter int unsigned BLK_SHIFT     = 16,
    parameter int unsigned PROT_BLKS [16] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 256,
                                              512, 1024, 2048, 4096, 8192, 16384}
) (
    input  logic [3:0]                  bp,
    input  logic [ADDR_W-BLK_SHIFT-1:0] blk_idx,
    output logic                        prot_hit,
    output logic                        any_prot
);
    localparam int unsigned NUM_BLOCKS = 1 << (ADDR_W - BLK_SHIFT);

    int unsigned count;
    int unsigned base;

    always_comb begin
        count = PROT_BLKS[bp];
        if (count > NUM_BLOCKS)
            count = NUM_BLOCKS;
        base     = NUM_BLOCKS - count;
        prot_hit = (32'(blk_idx) >= base);
        any_prot = (count != 0);
    end
endmodule

// File: rtl/fwp_cmd_judge.sv
module fwp_cmd_judge
    import fwp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned LEN_W     = 12,
    parameter int unsigned OTP_BYTES = 64
) (
    input  logic              cmd_valid,
    input  logic [7:0]        op,
    input  logic [LEN_W-1:0]  bits,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wprot_n,
    input  gate_state_t       st,
    input  logic              puw_done,
    input  logic              fact_lock,
    input  logic              prot_hit,
    input  logic              any_prot,
    output verdict_t          v
);
    localparam int unsigned ABYTES = (ADDR_W + 7) / 8;

    logic len_ok;
    logic otp_in_range;
    logic hw_lock;

    always_comb begin
        len_ok       = ((bits & LEN_W'(7)) == '0) &&
                       (32'(bits >> 3) >= min_bytes(op, ABYTES));
        otp_in_range = (32'(addr) < OTP_BYTES);
        hw_lock      = st.srwd & ~wprot_n;

        v      = '0;
        v.kind = LK_NONE;

        if (!cmd_valid || !len_ok || !is_known(op)) begin
            v = '0;
        end else if (st.dpd) begin
            if (op == OP_WAKE) begin
                v.accept  = 1'b1;
                v.clr_dpd = 1'b1;
            end
        end else if (st.busy) begin
            if (op == OP_STAT_READ)
                v.accept = 1'b1;
        end else if (is_write_cls(op) && !puw_done) begin
            v = '0;
        end else begin
            case (op)
                OP_WR_ENABLE: begin
                    v.accept  = 1'b1;
                    v.set_wel = 1'b1;
                end
                OP_WR_DISABLE: begin
                    v.accept  = 1'b1;
                    v.clr_wel = 1'b1;
                end
                OP_STAT_WRITE: begin
                    if (st.wel && !hw_lock) begin
                        v.accept  = 1'b1;
                        v.wr_stat = 1'b1;
                        v.clr_wel = 1'b1;
                    end
                end
                OP_PAGE_PROG: begin
                    if (st.wel) begin
                        if (st.otp) begin
                            if (!fact_lock && !st.cust && otp_in_range) begin
                                v.accept = 1'b1;
                                v.kind   = LK_PROG;
                            end
                        end else if (!prot_hit) begin
                            v.accept = 1'b1;
                            v.kind   = LK_PROG;
                        end
                    end
                end
                OP_SECT_ERASE: begin
                    if (st.wel && !st.otp && !prot_hit) begin
                        v.accept = 1'b1;
                        v.kind   = LK_SECT;
                    end
                end
                OP_BLK_ERASE: begin
                    if (st.wel && !st.otp && !prot_hit) begin
                        v.accept = 1'b1;
                        v.kind   = LK_BLOCK;
                    end
                end
                OP_CHIP_ERASE: begin
                    if (st.wel && !st.otp && !any_prot) begin
                        v.accept = 1'b1;
                        v.kind   = LK_CHIP;
                    end
                end
                OP_PWR_DOWN: begin
                    v.accept  = 1'b1;
                    v.set_dpd = 1'b1;
                end
                OP_OTP_ENTER: begin
                    v.accept  = 1'b1;
                    v.set_otp = 1'b1;
                end
                OP_OTP_EXIT: begin
                    v.accept  = 1'b1;
                    v.clr_otp = 1'b1;
                end
                OP_SEC_WRITE: begin
                    if (st.wel) begin
                        v.accept   = 1'b1;
                        v.set_cust = 1'b1;
                    end
                end
                default: v.accept = 1'b1; // read, status read, signature read
            endcase
        end
    end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
    import fwp_pkg::*;
#(
    parameter int unsigned ADDR_W        = 24,
    parameter int unsigned BLK_SHIFT     = 16,
    parameter int unsigned LEN_W         = 12,
    parameter int unsigned PUW_CYCLES    = 2000,
    parameter int unsigned OTP_BYTES     = 64,
    parameter int unsigned PROT_BLKS [16] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 256,
                                              512, 1024, 2048, 4096, 8192, 16384}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [LEN_W-1:0]  cmd_bits,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wprot_n,
    input  logic              otp_factory_lock,
    input  logic              op_done,
    output logic              accept,
    output logic [2:0]        launch_kind,
    output logic [ADDR_W-1:0] launch_addr,
    output logic              launch_otp,
    output logic [7:0]        stat_reg,
    output logic [1:0]        sec_reg,
    output logic              deep_pd,
    output logic              otp_mode,
    output logic              wr_ready
);
    logic              wel_q, srwd_q, dpd_q, otp_q, cust_q, busy_q;
    logic [3:0]        bp_q;
    logic              accept_q;
    launch_kind_e      kind_q;
    logic [ADDR_W-1:0] laddr_q;
    logic              lotp_q;

    gate_state_t st;
    verdict_t    vd;
    logic        puw_done, prot_hit, any_prot;
    logic        unused_wdata;

    assign unused_wdata = ^{cmd_wdata[6], cmd_wdata[1:0]};

    always_comb begin
        st = '{wel: wel_q, srwd: srwd_q, dpd: dpd_q,
               otp: otp_q, cust: cust_q, busy: busy_q};
    end

    fwp_puw_timer #(.CYCLES(PUW_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .expired (puw_done)
    );

    fwp_prot_lookup #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT),
        .PROT_BLKS (PROT_BLKS)
    ) u_lookup (
        .bp       (bp_q),
        .blk_idx  (cmd_addr[ADDR_W-1:BLK_SHIFT]),
        .prot_hit (prot_hit),
        .any_prot (any_prot)
    );

    fwp_cmd_judge #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .OTP_BYTES (OTP_BYTES)
    ) u_judge (
        .cmd_valid (cmd_valid),
        .op        (cmd_op),
        .bits      (cmd_bits),
        .addr      (cmd_addr),
        .wprot_n   (wprot_n),
        .st        (st),
        .puw_done  (puw_done),
        .fact_lock (otp_factory_lock),
        .prot_hit  (prot_hit),
        .any_prot  (any_prot),
        .v         (vd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q    <= 1'b0;
            srwd_q   <= 1'b0;
            dpd_q    <= 1'b0;
            otp_q    <= 1'b0;
            cust_q   <= 1'b0;
            busy_q   <= 1'b0;
            bp_q     <= '0;
            accept_q <= 1'b0;
            kind_q   <= LK_NONE;
            laddr_q  <= '0;
            lotp_q   <= 1'b0;
        end else begin
            accept_q <= vd.accept;
            kind_q   <= vd.kind;

            // completion of an array operation drops busy and the latch
            if (busy_q && op_done) begin
                busy_q <= 1'b0;
                wel_q  <= 1'b0;
            end

            if (vd.set_wel) wel_q <= 1'b1;
            if (vd.clr_wel) wel_q <= 1'b0;
            if (vd.wr_stat) begin
                bp_q   <= cmd_wdata[5:2];
                srwd_q <= cmd_wdata[7];
            end
            if (vd.set_dpd)  dpd_q  <= 1'b1;
            if (vd.clr_dpd)  dpd_q  <= 1'b0;
            if (vd.set_otp)  otp_q  <= 1'b1;
            if (vd.clr_otp)  otp_q  <= 1'b0;
            if (vd.set_cust) cust_q <= 1'b1;

            if (vd.kind != LK_NONE) begin
                busy_q  <= 1'b1;
                laddr_q <= cmd_addr;
                lotp_q  <= otp_q;
            end
        end
    end

    assign accept      = accept_q;
    assign launch_kind = kind_q;
    assign launch_addr = laddr_q;
    assign launch_otp  = lotp_q;
    assign stat_reg    = {srwd_q, 1'b0, bp_q, wel_q, busy_q};
    assign sec_reg     = {cust_q, otp_factory_lock};
    assign deep_pd     = dpd_q;
    assign otp_mode    = otp_q;
    assign wr_ready    = puw_done;
endmodule

// File: rtl/fwp_gate_chk.sv
module fwp_gate_chk #(
    parameter int unsigned LEN_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [7:0]       cmd_op,
    input logic [LEN_W-1:0] cmd_bits,
    input logic             wprot_n,
    input logic             accept,
    input logic [2:0]       launch_kind,
    input logic [7:0]       stat_reg,
    input logic             deep_pd,
    input logic             wr_ready
);
    a_r12_launch_with_accept: assert property (@(posedge clk) disable iff (rst)
        (launch_kind != 3'd0) |-> accept);

    a_r3_launch_needs_latch: assert property (@(posedge clk) disable iff (rst)
        (launch_kind != 3'd0) |-> $past(stat_reg[1]));

    a_r5_partial_byte_dropped: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ((cmd_bits & LEN_W'(7)) != '0)) |=> !accept);

    a_r8_sleep_gate: assert property (@(posedge clk) disable iff (rst)
        (deep_pd && cmd_valid && cmd_op != 8'hAB) |=> !accept);

    a_r11_busy_gate: assert property (@(posedge clk) disable iff (rst)
        (stat_reg[0] && cmd_valid && cmd_op != 8'h05) |=> !accept);

    a_r7_pin_locks_status: assert property (@(posedge clk) disable iff (rst)
        (stat_reg[7] && !wprot_n) |=> (stat_reg[7:2] == $past(stat_reg[7:2])));

    a_r2_no_early_enable: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && cmd_valid && cmd_op == 8'h06) |=> !accept);
endmodule

bind flash_wp_gate fwp_gate_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bits    (cmd_bits),
    .wprot_n     (wprot_n),
    .accept      (accept),
    .launch_kind (launch_kind),
    .stat_reg    (stat_reg),
    .deep_pd     (deep_pd),
    .wr_ready    (wr_ready)
);

// File: tb/flash_wp_gate_test.sv
`timescale 1ns/1ps
module flash_wp_gate_test;
    localparam int AW  = 12;
    localparam int LW  = 12;
    localparam int PUW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_op = '0;
    logic [LW-1:0] cmd_bits = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_wdata = '0;
    logic          wprot_n = 1'b1;
    logic          otp_factory_lock = 1'b0;
    logic          op_done = 1'b0;
    logic          accept;
    logic [2:0]    launch_kind;
    logic [AW-1:0] launch_addr;
    logic          launch_otp;
    logic [7:0]    stat_reg;
    logic [1:0]    sec_reg;
    logic          deep_pd;
    logic          otp_mode;
    logic          wr_ready;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    flash_wp_gate #(
        .ADDR_W(AW), .BLK_SHIFT(8), .LEN_W(LW), .PUW_CYCLES(PUW)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .wprot_n(wprot_n), .otp_factory_lock(otp_factory_lock), .op_done(op_done),
        .accept(accept), .launch_kind(launch_kind), .launch_addr(launch_addr),
        .launch_otp(launch_otp), .stat_reg(stat_reg), .sec_reg(sec_reg),
        .deep_pd(deep_pd), .otp_mode(otp_mode), .wr_ready(wr_ready)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  nbits;
        logic [11:0] addr;
        logic [7:0]  data;
        logic        wp;
        logic        acc;
        logic [2:0]  kind;
        logic [7:0]  stat;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'h02, 8'd32, 12'h100, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00}, // R3 no latch
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h02}, // R3 enable
        '{8'h02, 8'd32, 12'h100, 8'h00, 1'b1, 1'b1, 3'd1, 8'h03}, // R12 program
        '{8'h02, 8'd32, 12'h100, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00}, // R4 cleared
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h02},
        '{8'h01, 8'd16, 12'h000, 8'h8C, 1'b1, 1'b1, 3'd0, 8'h8C}, // R7 lock+idx3
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h8E},
        '{8'h20, 8'd24, 12'hC10, 8'h00, 1'b1, 1'b0, 3'd0, 8'h8E}, // R6 guarded
        '{8'hD8, 8'd24, 12'h300, 8'h00, 1'b1, 1'b1, 3'd3, 8'h8F}, // R6 open
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h8E},
        '{8'hC7, 8'd8,  12'h000, 8'h00, 1'b1, 1'b0, 3'd0, 8'h8E}, // R6 chip
        '{8'h06, 8'd7,  12'h000, 8'h00, 1'b1, 1'b0, 3'd0, 8'h8E}, // R5
        '{8'h06, 8'd12, 12'h000, 8'h00, 1'b1, 1'b0, 3'd0, 8'h8E}, // R5
        '{8'h01, 8'd16, 12'h000, 8'h00, 1'b0, 1'b0, 3'd0, 8'h8E}, // R7 pin low
        '{8'h01, 8'd16, 12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h00}, // R7 pin high
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h02},
        '{8'hC7, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd4, 8'h03}, // R6 chip ok
        '{8'hB9, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h00}, // R8
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b0, 3'd0, 8'h00}, // R8 dropped
        '{8'hAB, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h00}, // R8 wake
        '{8'h06, 8'd8,  12'h000, 8'h00, 1'b1, 1'b1, 3'd0, 8'h02},
        '{8'h20, 8'd24, 12'hC10, 8'h00, 1'b1, 1'b1, 3'd2, 8'h03}  // R6 unguarded
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] op, input logic [LW-1:0] nb,
                       input logic [AW-1:0] a, input logic [7:0] d);
        cmd_op = op; cmd_bits = nb; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic done_pulse();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic power_on();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        power_on();
        // R1 reset state
        chk("R1 status", 32'(stat_reg), 32'h00);
        chk("R1 sleep", 32'(deep_pd), 0);
        chk("R1 otp", 32'(otp_mode), 0);
        chk("R1 sec", 32'(sec_reg), 0);
        chk("R1 accept", 32'(accept), 0);
        chk("R1 ready", 32'(wr_ready), 0);

        // R2 inhibit window
        cmd(8'h06, 8, 0, 0);
        chk("R2 early enable", 32'(accept), 0);
        cmd(8'h05, 8, 0, 0);
        chk("R2 read allowed", 32'(accept), 1);
        repeat (17) @(negedge clk);
        chk("R2 ready low", 32'(wr_ready), 0);
        @(negedge clk);
        chk("R2 ready high", 32'(wr_ready), 1);

        for (int i = 0; i < NV; i++) begin
            wprot_n = VECS[i].wp;
            cmd(VECS[i].op, LW'(VECS[i].nbits), VECS[i].addr, VECS[i].data);
            chk($sformatf("R12 vec%0d accept", i), 32'(accept), 32'(VECS[i].acc));
            chk($sformatf("R12 vec%0d kind", i), 32'(launch_kind), 32'(VECS[i].kind));
            chk($sformatf("R4 vec%0d status", i), 32'(stat_reg), 32'(VECS[i].stat));
            if (VECS[i].kind != 3'd0) begin
                done_pulse();
                chk($sformatf("R4 vec%0d after done", i), 32'(stat_reg),
                    32'(VECS[i].stat & 8'hFC));
            end
        end
        wprot_n = 1'b1;

        // R5 byte-aligned but short
        cmd(8'h06, 8, 0, 0);
        cmd(8'h02, 24, 12'h100, 0);
        chk("R5 short program", 32'(accept), 0);

        // R12 launch fields, R11 busy
        cmd(8'h02, 40, 12'h1A5, 0);
        chk("R12 kind", 32'(launch_kind), 1);
        chk("R12 addr", 32'(launch_addr), 32'h1A5);
        chk("R12 otp", 32'(launch_otp), 0);
        cmd(8'h06, 8, 0, 0);
        chk("R11 busy drop", 32'(accept), 0);
        cmd(8'h05, 8, 0, 0);
        chk("R11 status read", 32'(accept), 1);
        chk("R11 busy bit", 32'(stat_reg[0]), 1);
        done_pulse();
        chk("R11 idle", 32'(stat_reg), 0);

        // R7 pin ignored with lock bit clear, R6 boundary at index 4
        wprot_n = 1'b0;
        cmd(8'h06, 8, 0, 0);
        cmd(8'h01, 16, 0, 8'h10);
        chk("R7 pin ignored", 32'(stat_reg), 32'h10);
        wprot_n = 1'b1;
        cmd(8'h06, 8, 0, 0);
        cmd(8'h02, 32, 12'h7FF, 0);
        chk("R6 below edge", 32'(launch_kind), 1);
        done_pulse();
        cmd(8'h06, 8, 0, 0);
        cmd(8'h02, 32, 12'h800, 0);
        chk("R6 at edge", 32'(accept), 0);
        cmd(8'h01, 16, 0, 8'h00);
        chk("R6 cleared", 32'(stat_reg), 0);

        // R8 flag
        cmd(8'hB9, 8, 0, 0);
        chk("R8 enter", 32'(deep_pd), 1);
        cmd(8'hAB, 8, 0, 0);
        chk("R8 leave", 32'(deep_pd), 0);

        // R9 and R10 OTP window
        cmd(8'hB1, 8, 0, 0);
        chk("R9 enter", 32'(otp_mode), 1);
        cmd(8'h06, 8, 0, 0);
        cmd(8'h02, 32, 12'h03F, 0);
        chk("R9 last byte kind", 32'(launch_kind), 1);
        chk("R9 otp target", 32'(launch_otp), 1);
        done_pulse();
        cmd(8'h06, 8, 0, 0);
        cmd(8'h02, 32, 12'h040, 0);
        chk("R9 out of range", 32'(accept), 0);
        cmd(8'h20, 24, 12'h000, 0);
        chk("R9 erase dropped", 32'(accept), 0);
        cmd(8'h2F, 8, 0, 0);
        chk("R10 cust lock", 32'(sec_reg), 2);
        chk("R10 latch kept", 32'(stat_reg[1]), 1);
        cmd(8'h02, 32, 12'h000, 0);
        chk("R10 locked program", 32'(accept), 0);
        cmd(8'hC1, 8, 0, 0);
        chk("R9 exit", 32'(otp_mode), 0);
        cmd(8'h02, 32, 12'h000, 0);
        chk("R9 main kind", 32'(launch_kind), 1);
        chk("R9 main target", 32'(launch_otp), 0);
        done_pulse();

        // R10 factory lock
        power_on();
        otp_factory_lock = 1'b1;
        repeat (PUW + 1) @(negedge clk);
        chk("R10 factory bit", 32'(sec_reg), 1);
        cmd(8'hB1, 8, 0, 0);
        cmd(8'h06, 8, 0, 0);
        cmd(8'h02, 32, 12'h000, 0);
        chk("R10 factory program", 32'(accept), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule